// File: doc/BRIEF.md
# Overlapping Chip-Select Decoder with Wait-State Merging

This block compares each bus cycle against a small set of programmable address windows and pulls low the select line of every window the cycle falls into. A window is described by its first and last block, the address space it serves (memory or I/O), the number of wait clocks it wants and whether it must also wait for an external ready signal. Memory windows are compared in 1 KB blocks and I/O windows in 64-byte blocks.

Windows may overlap. The block then does not pick one winner. It folds all matching windows into one timing policy. If no matching window listens to ready, the cycle takes the longest wait count among them and ignores ready. If any matching window listens to ready, the cycle takes the shortest wait count among all of them and then also waits for ready. The block counts out the wait clocks, watches ready when needed, holds the select lines for the whole cycle and raises a one-clock completion pulse. A separate flag marks I/O cycles that fall in the reserved byte range F8h to FFh.

Windows are loaded through a single-word write port. Cycles are started with a one-clock start pulse that carries the address, the cycle kind and the code of the unit that started the cycle.

Top module: `cs_wait_merge`

## Requirements
- R1: A window matches when its enable bit is set and lo <= key <= hi. For a memory cycle the key is address bits [19:10]. For an I/O cycle the key is address bits [15:6].
- R2: Cycle kind codes are 0 I/O read, 1 I/O write, 2 memory read, 3 memory write, 4 instruction fetch, and 5 to 7 other. Windows whose space bit is 1 match only kinds 2 to 4. Windows whose space bit is 0 match only kinds 0 and 1. Kinds 5 to 7 match no window.
- R3: Initiator codes 0 (CPU), 1 (DMA) and 2 (refresh) may assert selects. Code 3 asserts none.
- R4: When no matching window requires ready, the cycle uses the largest wait count among the matches and ignores bus_rdy.
- R5: When any matching window requires ready, the cycle uses the smallest wait count among all matches and requires bus_rdy.
- R6: With start sampled at clock edge 0 and merged wait count W, when ready is ignored, cyc_done is high for exactly the clock that follows edge W+1.
- R7: When ready is required, cyc_done follows the first edge at or after edge W+1 at which bus_rdy is sampled high.
- R8: From the edge that samples start until the edge after cyc_done, cs_n holds the active-low match vector, with bit i belonging to window i. cs_n returns to all ones on that edge, and cyc_done lasts one clock.
- R9: A cycle with no match asserts no select, uses zero wait clocks and ignores bus_rdy.
- R10: io_resv_hit is high for the whole cycle when an I/O-kind cycle has address[15:0] in F8h..FFh. It does not change matching.
- R11: A write with cfg_we high loads window cfg_sel from cfg_data. The fields are: bit 0 enable, bit 1 space (1 memory), bit 2 ready required, bits [6:3] wait count, bits [16:7] lo, bits [26:17] hi.
- R12: Synchronous reset drives cs_n to all ones, clears cyc_done and io_resv_hit, and disables every window.
- R13: A start pulse during a cycle in progress is ignored. It changes neither the selects nor the completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_sel | input | 2 | Window index to write |
| cfg_data | input | 27 | Packed window settings |
| cyc_start | input | 1 | One-clock start of a bus cycle |
| cyc_addr | input | 20 | Cycle address |
| cyc_kind | input | 3 | Cycle kind code |
| cyc_src | input | 2 | Initiator code |
| bus_rdy | input | 1 | External ready |
| cs_n | output | 4 | Active-low selects, one per window |
| cyc_done | output | 1 | Cycle completion pulse |
| io_resv_hit | output | 1 | Reserved I/O range flag |

## Verification
The selects and the reserved flag are registered on the edge that samples start, so the bench reads them at the falling edge right after that edge. It then keeps reading them at every following falling edge until completion. The bench counts rising edges from the start edge and expects cyc_done after edge W+1, or after the first later edge with ready high. Ready is only raised at a falling edge, a known number of edges after start, so the expected edge follows directly. One falling edge after completion, the bench expects all selects released and the pulse gone.

// File: rtl/cswm_pkg.sv
package cswm_pkg;
  typedef enum logic [2:0] {
    K_IO_RD  = 3'd0,
    K_IO_WR  = 3'd1,
    K_MEM_RD = 3'd2,
    K_MEM_WR = 3'd3,
    K_FETCH  = 3'd4,
    K_OTH5   = 3'd5,
    K_OTH6   = 3'd6,
    K_OTH7   = 3'd7
  } cyc_kind_e;

  typedef enum logic [1:0] {
    SRC_CPU   = 2'd0,
    SRC_DMA   = 2'd1,
    SRC_RFSH  = 2'd2,
    SRC_OTHER = 2'd3
  } cyc_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  function automatic logic kind_is_mem(input logic [2:0] k);
    return (k == K_MEM_RD) || (k == K_MEM_WR) || (k == K_FETCH);
  endfunction

  function automatic logic kind_is_io(input logic [2:0] k);
    return (k == K_IO_RD) || (k == K_IO_WR);
  endfunction
endpackage

// File: rtl/cswm_cfg.sv
module cswm_cfg #(
  parameter int N_REG = 4,
  parameter int WSW   = 4,
  parameter int BW    = 10,
  localparam int SELW  = (N_REG > 1) ? $clog2(N_REG) : 1,
  localparam int CFG_W = 3 + WSW + 2 * BW
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [SELW-1:0]               sel,
  input  logic [CFG_W-1:0]              data,
  output logic [N_REG-1:0]              en,
  output logic [N_REG-1:0]              is_mem,
  output logic [N_REG-1:0]              need_rdy,
  output logic [N_REG-1:0][WSW-1:0]     wt,
  output logic [N_REG-1:0][BW-1:0]      lo,
  output logic [N_REG-1:0][BW-1:0]      hi
);
  localparam int WT_LSB = 3;
  localparam int LO_LSB = WT_LSB + WSW;
  localparam int HI_LSB = LO_LSB + BW;

  for (genvar g = 0; g < N_REG; g++) begin : g_win
    logic hit_sel;
    assign hit_sel = we && (sel == SELW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        en[g]       <= 1'b0;
        is_mem[g]   <= 1'b0;
        need_rdy[g] <= 1'b0;
        wt[g]       <= '0;
        lo[g]       <= '0;
        hi[g]       <= '0;
      end else if (hit_sel) begin
        en[g]       <= data[0];
        is_mem[g]   <= data[1];
        need_rdy[g] <= data[2];
        wt[g]       <= data[LO_LSB-1:WT_LSB];
        lo[g]       <= data[HI_LSB-1:LO_LSB];
        hi[g]       <= data[CFG_W-1:HI_LSB];
      end
    end
  end
endmodule

// File: rtl/cswm_decode.sv
module cswm_decode
  import cswm_pkg::*;
#(
  parameter int N_REG  = 4,
  parameter int AW     = 20,
  parameter int IO_AW  = 16,
  parameter int MEM_LG = 10,
  parameter int IO_LG  = 6,
  parameter int BW     = 10
) (
  input  logic [AW-1:0]             addr,
  input  logic [2:0]                kind,
  input  logic [1:0]                src,
  input  logic [N_REG-1:0]          en,
  input  logic [N_REG-1:0]          is_mem,
  input  logic [N_REG-1:0][BW-1:0]  lo,
  input  logic [N_REG-1:0][BW-1:0]  hi,
  output logic [N_REG-1:0]          hit,
  output logic                      resv
);
  localparam logic [IO_AW-4:0] RSV_TAG = (IO_AW-3)'(31);

  logic [BW-1:0] mkey, ikey;
  logic          mem_cyc, io_cyc, src_ok;
  logic          unused_low;

  assign mkey       = BW'(addr[AW-1:MEM_LG]);
  assign ikey       = BW'(addr[IO_AW-1:IO_LG]);
  assign mem_cyc    = kind_is_mem(kind);
  assign io_cyc     = kind_is_io(kind);
  assign src_ok     = (src != SRC_OTHER);
  assign resv       = io_cyc && (addr[IO_AW-1:3] == RSV_TAG);
  assign unused_low = ^addr[2:0];

  for (genvar g = 0; g < N_REG; g++) begin : g_cmp
    logic [BW-1:0] key;
    logic          space_ok;
    assign key      = is_mem[g] ? mkey : ikey;
    assign space_ok = is_mem[g] ? mem_cyc : io_cyc;
    assign hit[g]   = en[g] && space_ok && src_ok && (key >= lo[g]) && (key <= hi[g]);
  end
endmodule

// File: rtl/cswm_merge.sv
module cswm_merge #(
  parameter int N_REG = 4,
  parameter int WSW   = 4
) (
  input  logic [N_REG-1:0]          hit,
  input  logic [N_REG-1:0]          need_rdy,
  input  logic [N_REG-1:0][WSW-1:0] wt,
  output logic [WSW-1:0]            wt_out,
  output logic                      rdy_out
);
  logic [WSW-1:0] mx, mn;
  logic           any_rdy;

  always_comb begin
    mx      = '0;
    mn      = '1;
    any_rdy = 1'b0;
    for (int i = 0; i < N_REG; i++) begin
      if (hit[i]) begin
        if (wt[i] > mx) mx = wt[i];
        if (wt[i] < mn) mn = wt[i];
        if (need_rdy[i]) any_rdy = 1'b1;
      end
    end
  end

  assign rdy_out = any_rdy;
  assign wt_out  = any_rdy ? mn : mx;
endmodule

// File: rtl/cswm_seq.sv
module cswm_seq
  import cswm_pkg::*;
#(
  parameter int N_REG = 4,
  parameter int WSW   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N_REG-1:0] hit,
  input  logic [WSW-1:0]   wt,
  input  logic             rdy_mode,
  input  logic             resv,
  input  logic             bus_rdy,
  output logic [N_REG-1:0] cs_n,
  output logic             done,
  output logic             resv_q,
  output logic             busy,
  output logic             rdy_q
);
  seq_state_e     st;
  logic [WSW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      cs_n   <= '1;
      done   <= 1'b0;
      resv_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          cs_n   <= ~hit;
          cnt    <= wt;
          rdy_q  <= rdy_mode;
          resv_q <= resv;
          st     <= ST_RUN;
        end
        ST_RUN: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (!rdy_q || bus_rdy) begin
            done <= 1'b1;
            st   <= ST_FIN;
          end
        end
        ST_FIN: begin
          done   <= 1'b0;
          cs_n   <= '1;
          resv_q <= 1'b0;
          rdy_q  <= 1'b0;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/cs_wait_merge.sv
module cs_wait_merge #(
  parameter int N_REG  = 4,
  parameter int AW     = 20,
  parameter int IO_AW  = 16,
  parameter int MEM_LG = 10,
  parameter int IO_LG  = 6,
  parameter int WSW    = 4,
  localparam int MBW   = AW - MEM_LG,
  localparam int IBW   = IO_AW - IO_LG,
  localparam int BW    = (MBW > IBW) ? MBW : IBW,
  localparam int SELW  = (N_REG > 1) ? $clog2(N_REG) : 1,
  localparam int CFG_W = 3 + WSW + 2 * BW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SELW-1:0]  cfg_sel,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             cyc_start,
  input  logic [AW-1:0]    cyc_addr,
  input  logic [2:0]       cyc_kind,
  input  logic [1:0]       cyc_src,
  input  logic             bus_rdy,
  output logic [N_REG-1:0] cs_n,
  output logic             cyc_done,
  output logic             io_resv_hit
);
  logic [N_REG-1:0]          en, is_mem, need_rdy, hit;
  logic [N_REG-1:0][WSW-1:0] wt;
  logic [N_REG-1:0][BW-1:0]  lo, hi;
  logic [WSW-1:0]            m_wt;
  logic                      m_rdy, resv, busy, rdy_hold;

  cswm_cfg #(.N_REG(N_REG), .WSW(WSW), .BW(BW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
    .en(en), .is_mem(is_mem), .need_rdy(need_rdy), .wt(wt), .lo(lo), .hi(hi)
  );

  cswm_decode #(.N_REG(N_REG), .AW(AW), .IO_AW(IO_AW), .MEM_LG(MEM_LG),
                .IO_LG(IO_LG), .BW(BW)) u_dec (
    .addr(cyc_addr), .kind(cyc_kind), .src(cyc_src), .en(en), .is_mem(is_mem),
    .lo(lo), .hi(hi), .hit(hit), .resv(resv)
  );

  cswm_merge #(.N_REG(N_REG), .WSW(WSW)) u_mrg (
    .hit(hit), .need_rdy(need_rdy), .wt(wt), .wt_out(m_wt), .rdy_out(m_rdy)
  );

  cswm_seq #(.N_REG(N_REG), .WSW(WSW)) u_seq (
    .clk(clk), .rst(rst), .start(cyc_start), .hit(hit), .wt(m_wt),
    .rdy_mode(m_rdy), .resv(resv), .bus_rdy(bus_rdy), .cs_n(cs_n),
    .done(cyc_done), .resv_q(io_resv_hit), .busy(busy), .rdy_q(rdy_hold)
  );
endmodule

// File: rtl/cswm_chk.sv
module cswm_chk #(
  parameter int N_REG = 4,
  parameter int AW    = 20,
  parameter int IO_AW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_start,
  input logic [AW-1:0]    cyc_addr,
  input logic [2:0]       cyc_kind,
  input logic [1:0]       cyc_src,
  input logic             bus_rdy,
  input logic [N_REG-1:0] cs_n,
  input logic             cyc_done,
  input logic             io_resv_hit,
  input logic             busy,
  input logic             rdy_hold
);
  logic unused_addr;
  assign unused_addr = ^cyc_addr;

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> (&cs_n && !cyc_done && !io_resv_hit));

  p_cs_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !cyc_done) |=> $stable(cs_n));

  p_src_block_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !busy && cyc_src == 2'd3) |=> &cs_n);

  p_kind_block_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !busy && cyc_kind > 3'd4) |=> &cs_n);

  p_ready_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (cyc_done && rdy_hold) |-> $past(bus_rdy));

  p_resv_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !busy && cyc_kind < 3'd2 && cyc_addr[IO_AW-1:3] == (IO_AW-3)'(31))
      |=> io_resv_hit);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (&cs_n && !cyc_done));
endmodule

bind cs_wait_merge cswm_chk #(.N_REG(N_REG), .AW(AW), .IO_AW(IO_AW)) u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
  .cyc_kind(cyc_kind), .cyc_src(cyc_src), .bus_rdy(bus_rdy), .cs_n(cs_n),
  .cyc_done(cyc_done), .io_resv_hit(io_resv_hit), .busy(busy), .rdy_hold(rdy_hold)
);

// File: tb/sim_cs_wait_merge.sv
module sim_cs_wait_merge;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [26:0] cfg_data = '0;
  logic        cyc_start = 1'b0;
  logic [19:0] cyc_addr = '0;
  logic [2:0]  cyc_kind = '0;
  logic [1:0]  cyc_src = '0;
  logic        bus_rdy = 1'b0;
  logic [N-1:0] cs_n;
  logic        cyc_done, io_resv_hit;

  int n_chk = 0, n_err = 0;
  bit m_en[N], m_mem[N], m_rq[N];
  int m_wt[N], m_lo[N], m_hi[N];

  always #2 clk = ~clk;

  cs_wait_merge u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .cyc_start(cyc_start), .cyc_addr(cyc_addr), .cyc_kind(cyc_kind),
    .cyc_src(cyc_src), .bus_rdy(bus_rdy), .cs_n(cs_n), .cyc_done(cyc_done),
    .io_resv_hit(io_resv_hit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R11 field layout: en[0] mem[1] rdy[2] wait[6:3] lo[16:7] hi[26:17]
  task automatic cfg_win(input int idx, input bit en, input bit mem, input bit rq,
                         input int wt, input int lo, input int hi);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_sel  = 2'(idx);
    cfg_data = {10'(hi), 10'(lo), 4'(wt), rq, mem, en};
    @(negedge clk);
    cfg_we = 1'b0;
    m_en[idx] = en; m_mem[idx] = mem; m_rq[idx] = rq;
    m_wt[idx] = wt; m_lo[idx] = lo; m_hi[idx] = hi;
  endtask

  function automatic logic [N-1:0] exp_hits(input logic [19:0] a, input int k, input int s);
    logic [N-1:0] h = '0;
    bit memc = (k >= 2 && k <= 4);
    bit ioc  = (k <= 1);
    for (int i = 0; i < N; i++) begin
      int key = m_mem[i] ? int'(a[19:10]) : int'(a[15:6]);
      bit sp  = m_mem[i] ? memc : ioc;
      if (m_en[i] && sp && s != 3 && key >= m_lo[i] && key <= m_hi[i]) h[i] = 1'b1;
    end
    return h;
  endfunction

  task automatic run_cyc(input logic [19:0] a, input int k, input int s, input int dr,
                         input bit poke, input string req);
    logic [N-1:0] eh = exp_hits(a, k, s);
    bit er = 1'b0;
    int ew, mx = 0, mn = 15, n = 0, expn, done_n = -1;
    bit ef = (k <= 1) && (a[15:0] >= 16'h00F8) && (a[15:0] <= 16'h00FF);
    bit cs_ok = 1'b1, fl_ok = 1'b1;
    for (int i = 0; i < N; i++) if (eh[i]) begin
      if (m_wt[i] > mx) mx = m_wt[i];
      if (m_wt[i] < mn) mn = m_wt[i];
      if (m_rq[i]) er = 1'b1;
    end
    ew = (eh == '0) ? 0 : (er ? mn : mx);
    expn = er ? ((dr + 1 > ew + 1) ? dr + 1 : ew + 1) : ew + 1;
    @(negedge clk);
    cyc_start = 1'b1; cyc_addr = a; cyc_kind = 3'(k); cyc_src = 2'(s);
    bus_rdy = (dr == 0);
    @(posedge clk);
    @(negedge clk);
    cyc_start = 1'b0;
    while (n < 200) begin
      if (cs_n != ~eh) cs_ok = 1'b0;
      if (io_resv_hit != ef) fl_ok = 1'b0;
      cyc_start = (poke && n == 1);
      if (poke && n == 1) cyc_addr = a ^ 20'hFFFFF;
      if (cyc_done) begin done_n = n; break; end
      if (n >= dr) bus_rdy = 1'b1;
      @(posedge clk); n++;
      @(negedge clk);
    end
    cyc_start = 1'b0;
    chk(done_n == expn, req, "done edge", done_n, expn);
    chk(cs_ok, req, "cs_n during cycle", int'(cs_n), int'(~eh));
    chk(fl_ok, "R10", "reserved flag", int'(io_resv_hit), int'(ef));
    @(posedge clk);
    @(negedge clk);
    chk(&cs_n && !cyc_done && !io_resv_hit, "R8", "release after done",
        int'({cyc_done, io_resv_hit, cs_n}), int'(N'('1)));
    bus_rdy = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin
      m_en[i] = 0; m_mem[i] = 0; m_rq[i] = 0; m_wt[i] = 0; m_lo[i] = 0; m_hi[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(&cs_n && !cyc_done && !io_resv_hit, "R12", "reset outputs",
        int'({cyc_done, io_resv_hit, cs_n}), int'(N'('1)));
    // R12 / R9: no window enabled after reset
    run_cyc(20'h01000, 2, 0, 5, 0, "R9");

    // R1 / R11: memory window blocks 4..6
    cfg_win(0, 1, 1, 0, 2, 4, 6);
    run_cyc(20'h00FFF, 2, 0, 0, 0, "R1");
    run_cyc(20'h01000, 2, 0, 0, 0, "R1");
    run_cyc(20'h01BFF, 3, 1, 0, 0, "R1");
    run_cyc(20'h01C00, 4, 2, 0, 0, "R1");

    // R4: 3 and 9, both ignoring ready -> 9
    cfg_win(1, 1, 1, 0, 3, 5, 5);
    cfg_win(2, 1, 1, 0, 9, 5, 8);
    run_cyc(20'h01400, 2, 0, 12, 0, "R4");
    // R5: 5 requiring ready and 0 ignoring -> 0 with ready
    cfg_win(1, 1, 1, 1, 5, 5, 5);
    cfg_win(2, 1, 1, 0, 0, 5, 8);
    run_cyc(20'h01400, 2, 0, 6, 0, "R5");
    run_cyc(20'h01400, 2, 0, 0, 0, "R7");
    // two windows requiring ready, both 2 -> 2 with ready
    cfg_win(1, 1, 1, 1, 2, 5, 5);
    cfg_win(2, 1, 1, 1, 2, 5, 8);
    run_cyc(20'h01400, 3, 1, 1, 0, "R5");
    run_cyc(20'h01400, 3, 1, 7, 0, "R7");
    run_cyc(20'h01400, 3, 1, 0, 0, "R6");

    // R2: I/O window on block 3; memory cycles and kinds 5..7 miss it
    cfg_win(3, 1, 0, 0, 4, 3, 3);
    run_cyc(20'h000C4, 0, 0, 0, 0, "R2");
    run_cyc(20'h000C4, 2, 0, 0, 0, "R2");
    run_cyc(20'h01400, 1, 0, 0, 0, "R2");
    run_cyc(20'h01400, 5, 0, 0, 0, "R2");
    run_cyc(20'h000C4, 7, 0, 0, 0, "R2");
    // R3: initiator code 3 asserts nothing
    run_cyc(20'h000C4, 1, 3, 0, 0, "R3");
    run_cyc(20'h01400, 2, 3, 9, 0, "R3");
    // R10: reserved window flagged, window still matches
    run_cyc(20'h000F8, 0, 2, 0, 0, "R10");
    run_cyc(20'h000FF, 1, 0, 0, 0, "R10");
    run_cyc(20'h000F7, 1, 0, 0, 0, "R10");
    // R13: start during a running cycle ignored
    run_cyc(20'h01400, 2, 0, 3, 1, "R13");
    run_cyc(20'h000C4, 0, 1, 0, 1, "R13");
    run_cyc(20'h01000, 2, 0, 0, 1, "R13");

    for (int t = 0; t < 400; t++) begin
      int k = $urandom % 8;
      int s = ($urandom % 8 == 0) ? 3 : $urandom % 3;
      logic [19:0] a;
      if (t % 15 == 0) begin
        int lo = $urandom % 8;
        cfg_win($urandom % N, ($urandom % 5) != 0, $urandom % 2, $urandom % 2,
                $urandom % 16, lo, lo + $urandom % 4);
      end
      if (k <= 1)
        a = ($urandom % 4 == 0) ? 20'(248 + $urandom % 8)
                                : 20'((($urandom % 12) << 6) | ($urandom % 64));
      else
        a = 20'((($urandom % 12) << 10) | ($urandom % 1024));
      run_cyc(a, k, s, $urandom % 20, ($urandom % 6 == 0), "R6");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule